// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block runs short programs that tell a serial flash controller what to put on the wire. Each program is a sequence of up to eight 16-bit instructions. The sequences sit in a small table that is written one 32-bit word at a time. A start request names a sequence, says what triggered it (an IP command, a bus read or a bus write) and selects single or double data rate. The interpreter then walks the sequence. It hands each executable instruction downstream as a step with an opcode, a lane-count code and an 8-bit operand. It holds chip select for as long as the sequence runs.

A sequence ends on a stop instruction, on a jump instruction, or after its eighth instruction. A jump is legal only in a bus-read sequence. It stores its operand as the instruction index at which the next bus-read sequence begins. Some instructions are illegal: a jump from an IP command or a bus write, an unknown opcode, or a dummy of the wrong rate. A step may also stall for too long. In each of these cases the sequence is abandoned and an error code is latched with the sequence index that failed.

The controller has three states. IDLE waits for a start. EXEC presents one instruction per step. CLOSE is a single cycle after a normal end. The transitions are: IDLE to EXEC on an accepted start. EXEC to EXEC while steps remain. EXEC to CLOSE on stop, jump, or acceptance of the eighth step. EXEC to IDLE on an error or a stall timeout. CLOSE to IDLE always.

Top module: `flash_seq_interp`

## Requirements
- R1: After reset, busy, cs_active, step_valid, done and err_flag are low and err_code is 0.
- R2: Sequence s occupies table words 4s to 4s+3. In each word the half in bits [15:0] runs before the half in bits [31:16]. Each instruction holds the operand in [7:0], the lane code in [9:8] (0, 1, 2, 3 for 1, 2, 4, 8 lines) and the opcode in [15:10]. These fields appear unchanged on step_opcode, step_lanes and step_operand.
- R3: A start is accepted only in IDLE. start_src is 0 for an IP command, 1 for a bus read and 2 for a bus write. From the next cycle, busy and cs_active are high. A start made while busy has no effect.
- R4: Opcode 0x00 ends the sequence. In the next cycle cs_active is low, done is high for exactly one cycle, and busy falls one cycle after that.
- R5: Opcodes 0x01 to 0x0D and 0x21 to 0x2D are presented as steps. The interpreter moves to the next instruction only in a cycle where step_valid and step_ready are both high. Opcodes 0x00 and 0x1F are never presented.
- R6: When the eighth instruction of a sequence is accepted as a step, the sequence ends exactly as it would on a stop.
- R7: In a bus-read sequence, opcode 0x1F ends the sequence like a stop and saves operand modulo 32 as an instruction index. The next accepted bus-read start begins at that index and uses it up. IP and bus-write starts leave the saved index untouched.
- R8: Opcode 0x1F in an IP or bus-write sequence is an error with code 0x2, and no index is saved.
- R9: Any opcode other than 0x00, 0x1F, 0x01 to 0x0D and 0x21 to 0x2D is an error with code 0x3.
- R10: Opcode 0x0C or 0x0D in a double-rate sequence is an error with code 0x4. Opcode 0x2C or 0x2D in a single-rate sequence is an error with code 0x5.
- R11: A step can be held valid and not ready for STALL_LIMIT (64) consecutive cycles. When that happens the sequence fails with code 0xE for an IP command and 0x6 for a bus trigger.
- R12: On any error, no done is given. The next cycle has busy and cs_active low and err_flag high. err_code and err_seq hold their values until err_clear, which resets all three; an error arriving in the same cycle as err_clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table word write enable |
| tbl_waddr | input | 4 | Table word address |
| tbl_wdata | input | 32 | Table word data (two instructions) |
| start_valid | input | 1 | Start request |
| start_seq | input | 2 | Sequence index to run |
| start_src | input | 2 | Trigger: 0 IP, 1 bus read, 2 bus write |
| start_ddr | input | 1 | 1 selects double data rate |
| busy | output | 1 | High from accepted start until back in IDLE |
| cs_active | output | 1 | Chip select request |
| step_valid | output | 1 | A step is offered |
| step_opcode | output | 6 | Step opcode |
| step_lanes | output | 2 | Step lane code |
| step_operand | output | 8 | Step operand |
| step_ready | input | 1 | Downstream accepts the step |
| done | output | 1 | One-cycle normal completion pulse |
| err_flag | output | 1 | Latched error indication |
| err_code | output | 4 | Latched error code |
| err_seq | output | 2 | Sequence index that failed |
| err_clear | input | 1 | Clears the latched error |

## Verification
The hardest state to reach is one that spans two sequences. It needs a bus-read sequence that ends in a jump, then an IP sequence that must ignore the saved index, then a bus-read start that must use it. A second bus-read start must then find the index already consumed. The stimulus runs these starts back to back. It places the jump target on a sequence whose contents give a different first opcode and a different outcome. Stall timeouts need step_ready held low for the full window, and the bench does this under each trigger type.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

    typedef enum logic [1:0] {
        SRC_IP = 2'd0,
        SRC_RD = 2'd1,
        SRC_WR = 2'd2,
        SRC_XX = 2'd3
    } src_e;

    typedef enum logic [3:0] {
        E_NONE    = 4'h0,
        E_JUMP    = 4'h2,
        E_UNKNOWN = 4'h3,
        E_SDR_DUM = 4'h4,
        E_DDR_DUM = 4'h5,
        E_BUS_TMO = 4'h6,
        E_IP_TMO  = 4'hE
    } err_e;

    typedef enum logic [1:0] {
        K_STEP,
        K_STOP,
        K_JUMP,
        K_FAULT
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_CLOSE
    } state_e;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] lanes;
        logic [7:0] arg;
    } instr_t;

    localparam logic [5:0] OP_STOP = 6'h00;
    localparam logic [5:0] OP_JUMP = 6'h1F;
    localparam logic [5:0] DDR_BIT = 6'h20;

endpackage

// File: rtl/fsi_lut.sv
module fsi_lut
    import fsi_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int AW    = 4,
    parameter int IPW   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [31:0]    wdata,
    input  logic [IPW-1:0] rptr,
    output instr_t         rins
);

    logic [31:0] mem [WORDS];
    logic [31:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign word = mem[rptr[IPW-1:1]];
    assign rins = rptr[0] ? word[31:16] : word[15:0];

endmodule

// File: rtl/fsi_decode.sv
module fsi_decode
    import fsi_pkg::*;
(
    input  instr_t ins,
    input  src_e   src,
    input  logic   ddr,
    output kind_e  kind,
    output err_e   code
);

    logic [4:0] low;
    logic       in_sdr;
    logic       in_ddr;
    logic       dummy;

    assign low    = ins.op[4:0];
    assign in_sdr = (ins.op[5] == 1'b0) && (low >= 5'd1) && (low <= 5'd13);
    assign in_ddr = (ins.op[5:4] == 2'b10) && (low >= 5'd1) && (low <= 5'd13);
    assign dummy  = (low == 5'd12) || (low == 5'd13);

    always_comb begin
        kind = K_STEP;
        code = E_NONE;
        if (ins.op == OP_STOP) begin
            kind = K_STOP;
        end else if (ins.op == OP_JUMP) begin
            if (src == SRC_RD) begin
                kind = K_JUMP;
            end else begin
                kind = K_FAULT;
                code = E_JUMP;
            end
        end else if (in_sdr && dummy && ddr) begin
            kind = K_FAULT;
            code = E_SDR_DUM;
        end else if (in_ddr && dummy && !ddr) begin
            kind = K_FAULT;
            code = E_DDR_DUM;
        end else if (!(in_sdr || in_ddr)) begin
            kind = K_FAULT;
            code = E_UNKNOWN;
        end
    end

endmodule

// File: rtl/fsi_stall_timer.sv
module fsi_stall_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (stall) cnt <= cnt + 1'b1;
        else            cnt <= '0;
    end

    assign expire = stall && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/flash_seq_interp.sv
module flash_seq_interp
    import fsi_pkg::*;
#(
    parameter  int NUM_SEQ     = 4,
    parameter  int STALL_LIMIT = 64,
    localparam int SW          = $clog2(NUM_SEQ),
    localparam int WAW         = SW + 2,
    localparam int IPW         = SW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tbl_we,
    input  logic [WAW-1:0] tbl_waddr,
    input  logic [31:0]    tbl_wdata,
    input  logic           start_valid,
    input  logic [SW-1:0]  start_seq,
    input  logic [1:0]     start_src,
    input  logic           start_ddr,
    output logic           busy,
    output logic           cs_active,
    output logic           step_valid,
    output logic [5:0]     step_opcode,
    output logic [1:0]     step_lanes,
    output logic [7:0]     step_operand,
    input  logic           step_ready,
    output logic           done,
    output logic           err_flag,
    output logic [3:0]     err_code,
    output logic [SW-1:0]  err_seq,
    input  logic           err_clear
);

    localparam int WORDS = NUM_SEQ * 4;

    state_e         state, nxt;
    logic [IPW-1:0] ptr, jptr, first_ptr;
    logic [2:0]     cnt;
    src_e           src;
    logic           ddr;
    logic [SW-1:0]  seq;
    logic           jvld;
    err_e           err_q;
    logic           err_q_flag;
    logic [SW-1:0]  err_q_seq;
    instr_t         cur;
    kind_e          kind;
    err_e           dcode;
    logic           stall, expire, use_jump;

    fsi_lut #(.WORDS(WORDS), .AW(WAW), .IPW(IPW)) u_lut (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_waddr),
        .wdata(tbl_wdata), .rptr(ptr), .rins(cur)
    );

    fsi_decode u_dec (
        .ins(cur), .src(src), .ddr(ddr), .kind(kind), .code(dcode)
    );

    assign stall = (state == ST_EXEC) && (kind == K_STEP) && !step_ready;

    fsi_stall_timer #(.LIMIT(STALL_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .stall(stall), .expire(expire)
    );

    assign use_jump  = (start_src == SRC_RD) && jvld;
    assign first_ptr = use_jump ? jptr : {start_seq, 3'b000};

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_valid) nxt = ST_EXEC;
            ST_EXEC: begin
                if (kind == K_FAULT || expire)              nxt = ST_IDLE;
                else if (kind == K_STOP || kind == K_JUMP)  nxt = ST_CLOSE;
                else if (step_ready && cnt == 3'd7)         nxt = ST_CLOSE;
            end
            ST_CLOSE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            cnt        <= '0;
            src        <= SRC_IP;
            ddr        <= 1'b0;
            seq        <= '0;
            jptr       <= '0;
            jvld       <= 1'b0;
            err_q      <= E_NONE;
            err_q_flag <= 1'b0;
            err_q_seq  <= '0;
        end else begin
            state <= nxt;
            if (err_clear) begin
                err_q_flag <= 1'b0;
                err_q      <= E_NONE;
                err_q_seq  <= '0;
            end
            case (state)
                ST_IDLE: begin
                    if (start_valid) begin
                        ptr <= first_ptr;
                        cnt <= '0;
                        src <= src_e'(start_src);
                        ddr <= start_ddr;
                        seq <= start_seq;
                        if (use_jump) jvld <= 1'b0;
                    end
                end
                ST_EXEC: begin
                    if (kind == K_FAULT) begin
                        err_q_flag <= 1'b1;
                        err_q      <= dcode;
                        err_q_seq  <= seq;
                    end else if (expire) begin
                        err_q_flag <= 1'b1;
                        err_q      <= (src == SRC_IP) ? E_IP_TMO : E_BUS_TMO;
                        err_q_seq  <= seq;
                    end else if (kind == K_JUMP) begin
                        jptr <= IPW'(cur.arg);
                        jvld <= 1'b1;
                    end else if (kind == K_STEP && step_ready) begin
                        ptr <= ptr + 1'b1;
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        cs_active    = (state == ST_EXEC);
        done         = (state == ST_CLOSE);
        step_valid   = (state == ST_EXEC) && (kind == K_STEP);
        step_opcode  = cur.op;
        step_lanes   = cur.lanes;
        step_operand = cur.arg;
        err_flag     = err_q_flag;
        err_code     = err_q;
        err_seq      = err_q_seq;
    end

endmodule

// File: rtl/fsi_chk.sv
module fsi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_valid,
    input logic       tbl_we,
    input logic       busy,
    input logic       cs_active,
    input logic       step_valid,
    input logic       step_ready,
    input logic [5:0] step_opcode,
    input logic [7:0] step_operand,
    input logic       done,
    input logic       err_flag,
    input logic       err_clear
);

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_valid));

    // R5
    step_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> cs_active);

    // R5
    step_not_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (step_opcode != 6'h00) && (step_opcode != 6'h1F));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid && !step_ready && !tbl_we |=>
            (step_valid && $stable(step_opcode) && $stable(step_operand)) || err_flag);

    // R4
    done_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cs_active && $past(cs_active));

    // R12
    err_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !busy && !done);

    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clear |=> err_flag);

endmodule

bind flash_seq_interp fsi_chk u_fsi_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .tbl_we(tbl_we),
    .busy(busy), .cs_active(cs_active), .step_valid(step_valid),
    .step_ready(step_ready), .step_opcode(step_opcode),
    .step_operand(step_operand), .done(done), .err_flag(err_flag),
    .err_clear(err_clear)
);

// File: tb/tb_flash_seq_interp.sv
`timescale 1ns/1ps
module tb_flash_seq_interp;

    localparam int LIM = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_waddr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        start_valid = 1'b0;
    logic [1:0]  start_seq = '0;
    logic [1:0]  start_src = '0;
    logic        start_ddr = 1'b0;
    logic        busy, cs_active, step_valid, done, err_flag;
    logic [5:0]  step_opcode;
    logic [1:0]  step_lanes;
    logic [7:0]  step_operand;
    logic        step_ready = 1'b0;
    logic [3:0]  err_code;
    logic [1:0]  err_seq;
    logic        err_clear = 1'b0;

    always #2.5 clk = ~clk;

    flash_seq_interp dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .start_valid(start_valid), .start_seq(start_seq),
        .start_src(start_src), .start_ddr(start_ddr), .busy(busy),
        .cs_active(cs_active), .step_valid(step_valid), .step_opcode(step_opcode),
        .step_lanes(step_lanes), .step_operand(step_operand),
        .step_ready(step_ready), .done(done), .err_flag(err_flag),
        .err_code(err_code), .err_seq(err_seq), .err_clear(err_clear)
    );

    int n_chk = 0, n_err = 0, n_done = 0, n_acc = 0, rmode = 0, cyc = 0;
    bit chk_on = 0;

    // behavioural reference
    logic [31:0] mt [16];
    int m_state, m_ptr, m_cnt, m_src, m_ddr, m_seq, m_wait;
    int m_jptr, m_jvld, m_err, m_code, m_eseq;

    function automatic int m_ins(int p);
        logic [31:0] w;
        w = mt[(p >> 1) % 16];
        return (p % 2 == 1) ? int'(w[31:16]) : int'(w[15:0]);
    endfunction

    function automatic int kind_of(int op, int src, int ddr, output int code);
        code = 0;
        if (op == 0) return 1;
        if (op == 31) begin
            if (src == 1) return 2;
            code = 2; return 3;
        end
        if ((op == 12 || op == 13) && ddr != 0) begin code = 4; return 3; end
        if ((op == 44 || op == 45) && ddr == 0) begin code = 5; return 3; end
        if ((op >= 1 && op <= 13) || (op >= 33 && op <= 45)) return 0;
        code = 3;
        return 3;
    endfunction

    function automatic logic [15:0] ins16(int op, int ln, int a);
        return {op[5:0], ln[1:0], a[7:0]};
    endfunction

    always @(posedge clk) begin
        int ins, k, code;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mt[i] = '0;
            m_state = 0; m_ptr = 0; m_cnt = 0; m_src = 0; m_ddr = 0; m_seq = 0;
            m_wait = 0; m_jptr = 0; m_jvld = 0; m_err = 0; m_code = 0; m_eseq = 0;
        end else begin
            ins = m_ins(m_ptr);
            k = kind_of(ins >> 10, m_src, m_ddr, code);
            if (err_clear) begin m_err = 0; m_code = 0; m_eseq = 0; end
            case (m_state)
                0: if (start_valid) begin
                    if (start_src == 2'd1 && m_jvld != 0) begin
                        m_ptr = m_jptr; m_jvld = 0;
                    end else m_ptr = int'(start_seq) * 8;
                    m_cnt = 0; m_src = int'(start_src); m_ddr = int'(start_ddr);
                    m_seq = int'(start_seq); m_wait = 0; m_state = 1;
                end
                1: begin
                    if (k == 3) begin
                        m_err = 1; m_code = code; m_eseq = m_seq; m_state = 0;
                    end else if (k == 1) m_state = 2;
                    else if (k == 2) begin
                        m_jptr = (ins & 255) % 32; m_jvld = 1; m_state = 2;
                    end else if (step_ready) begin
                        m_ptr = (m_ptr + 1) % 32; m_cnt++; m_wait = 0;
                        if (m_cnt == 8) m_state = 2;
                    end else begin
                        m_wait++;
                        if (m_wait == LIM) begin
                            m_err = 1; m_code = (m_src == 0) ? 14 : 6;
                            m_eseq = m_seq; m_state = 0;
                        end
                    end
                end
                default: m_state = 0;
            endcase
            if (tbl_we) mt[tbl_waddr] = tbl_wdata;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(posedge clk) begin
        #1;
        if (chk_on) begin
            int ins, k, c;
            bit sv;
            ins = m_ins(m_ptr);
            k = kind_of(ins >> 10, m_src, m_ddr, c);
            sv = (m_state == 1) && (k == 0);
            chk("R3 busy", int'(busy), int'(m_state != 0));
            chk("R3 cs_active", int'(cs_active), int'(m_state == 1));
            chk("R4 done", int'(done), int'(m_state == 2));
            chk("R5 step_valid", int'(step_valid), int'(sv));
            if (sv) begin
                chk("R2 opcode", int'(step_opcode), ins >> 10);
                chk("R2 lanes", int'(step_lanes), (ins >> 8) & 3);
                chk("R2 operand", int'(step_operand), ins & 255);
            end
            chk("R12 err_flag", int'(err_flag), m_err);
            chk("R12 err_code", int'(err_code), m_code);
            chk("R12 err_seq", int'(err_seq), m_eseq);
            if (done) n_done++;
        end
    end

    task automatic tick();
        @(negedge clk);
        cyc++;
        case (rmode)
            0: step_ready = 1'b1;
            1: step_ready = (cyc % 3 != 0);
            default: step_ready = 1'b0;
        endcase
        if (step_valid && step_ready) n_acc++;
    endtask

    task automatic wr(int a, logic [31:0] d);
        tbl_we = 1'b1; tbl_waddr = a[3:0]; tbl_wdata = d;
        tick();
        tbl_we = 1'b0;
    endtask

    task automatic run(int s, int src, int ddr);
        start_valid = 1'b1; start_seq = s[1:0]; start_src = src[1:0]; start_ddr = ddr[0];
        tick();
        start_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int g;
        g = 0;
        while (busy && g < 2000) begin tick(); g++; end
    endtask

    task automatic clr();
        err_clear = 1'b1;
        tick();
        err_clear = 1'b0;
    endtask

    task automatic go(int s, int src, int ddr, output int steps, output int dn);
        int a0, d0;
        a0 = n_acc; d0 = n_done;
        run(s, src, ddr);
        wait_idle();
        tick();
        steps = n_acc - a0; dn = n_done - d0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int st, dn;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 cs_active", int'(cs_active), 0);
        chk("R1 step_valid", int'(step_valid), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        chk("R1 err_code", int'(err_code), 0);

        // program the table
        wr(0,  {ins16(2, 2, 8'h18), ins16(1, 0, 8'hEB)});
        wr(1,  {ins16(9, 2, 4),     ins16(12, 2, 6)});
        wr(2,  {ins16(0, 0, 0),     ins16(8, 1, 8'h33)});
        wr(4,  {ins16(34, 1, 2),    ins16(33, 3, 8'h0B)});
        wr(5,  {ins16(36, 1, 4),    ins16(35, 2, 3)});
        wr(6,  {ins16(44, 2, 7),    ins16(38, 3, 5)});
        wr(7,  {ins16(41, 2, 8),    ins16(37, 1, 1)});
        wr(8,  {ins16(31, 0, 8),    ins16(1, 0, 6)});
        wr(12, {ins16(0, 0, 0),     ins16(13, 1, 3)});

        // R2 R4 R5: plain run, always ready, then with back-pressure
        rmode = 0; go(0, 0, 0, st, dn);
        chk("R5 steps", st, 5); chk("R4 done count", dn, 1);
        rmode = 1; go(0, 0, 0, st, dn);
        chk("R5 steps stalled", st, 5); chk("R4 done stalled", dn, 1);

        // R6 eight steps without stop
        rmode = 0; go(1, 0, 1, st, dn);
        chk("R6 steps", st, 8); chk("R6 done", dn, 1);
        rmode = 1; go(1, 2, 1, st, dn);
        chk("R6 steps stalled", st, 8); chk("R6 done stalled", dn, 1);

        // R10 double-rate dummy in single-rate sequence
        rmode = 0; go(1, 0, 0, st, dn);
        chk("R10 steps before fault", st, 5); chk("R12 no done", dn, 0);
        chk("R10 code 5", int'(err_code), 5); chk("R12 err_seq", int'(err_seq), 1);
        repeat (3) tick();
        chk("R12 latched", int'(err_flag), 1);
        clr();
        chk("R12 cleared flag", int'(err_flag), 0); chk("R12 cleared code", int'(err_code), 0);
        go(3, 0, 1, st, dn);
        chk("R10 code 4", int'(err_code), 4); chk("R10 no steps", st, 0);
        clr();
        go(3, 0, 0, st, dn);
        chk("R10 sdr dummy ok", dn, 1); chk("R10 no error", int'(err_flag), 0);

        // R7 jump from a bus read
        go(2, 1, 0, st, dn);
        chk("R7 jump ends", dn, 1); chk("R7 jump steps", st, 1);
        run(0, 0, 0);
        chk("R7 ip ignores ptr op", int'(step_opcode), 1);
        chk("R7 ip ignores ptr arg", int'(step_operand), 8'hEB);
        wait_idle(); tick();
        run(3, 1, 1);
        chk("R7 read uses ptr", int'(step_opcode), 8'h21);
        wait_idle(); tick();
        go(3, 1, 1, st, dn);
        chk("R7 ptr consumed code", int'(err_code), 4); chk("R7 ptr consumed seq", int'(err_seq), 3);
        clr();

        // R8 jump from IP and bus write
        go(2, 0, 0, st, dn);
        chk("R8 ip jump code", int'(err_code), 2); chk("R8 ip jump steps", st, 1);
        clr();
        go(2, 2, 0, st, dn);
        chk("R8 write jump code", int'(err_code), 2); chk("R8 write jump seq", int'(err_seq), 2);
        clr();
        go(3, 1, 1, st, dn);
        chk("R8 nothing saved", int'(err_code), 4);
        clr();

        // R9 unknown opcodes
        wr(12, {ins16(0, 0, 0), ins16(16, 0, 0)});
        go(3, 0, 0, st, dn);
        chk("R9 code 0x10", int'(err_code), 3);
        clr();
        wr(12, {ins16(0, 0, 0), ins16(46, 1, 0)});
        go(3, 1, 1, st, dn);
        chk("R9 code 0x2E", int'(err_code), 3);
        clr();

        // R11 stall timeout per trigger
        rmode = 2; go(0, 0, 0, st, dn);
        chk("R11 ip timeout", int'(err_code), 14); chk("R11 no done", dn, 0);
        clr();
        go(0, 2, 0, st, dn);
        chk("R11 write timeout", int'(err_code), 6);
        clr();
        go(0, 1, 0, st, dn);
        chk("R11 read timeout", int'(err_code), 6);
        clr();

        // R3 start while busy has no effect
        rmode = 1;
        begin
            int a0, d0;
            a0 = n_acc; d0 = n_done;
            run(0, 0, 0);
            tick(); tick();
            run(2, 1, 0);
            wait_idle(); tick();
            chk("R3 busy start ignored steps", n_acc - a0, 5);
            chk("R3 busy start ignored done", n_done - d0, 1);
            chk("R3 busy start no error", int'(err_flag), 0);
        end
        rmode = 0;
        repeat (4) tick();

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule